// File: doc/BRIEF.md
# Selectable-Input Timebase Prescaler

This block turns a free-running input clock of one of several known rates into a one-second timekeeping strobe. It also gives a set of slower sub-second taps for periodic interrupts and for a clock output pin. A 3-bit rate code tells the block which input rate to expect. The supported rates are a 32768 Hz watch crystal, 1, 2 or 4 MHz crystal or external clocks, and 50 Hz or 60 Hz mains-line clocks. Every rate gives an exact one-second strobe. The input clock is assumed to be already squared up. The oscillator and power switching sit outside this block.

A single fractional accumulator serves every rate. On each input cycle it adds 2^TAP_BITS to a running sum, modulo the selected input rate. Each time the sum wraps, it emits a fast strobe, so exactly 2^TAP_BITS fast strobes occur in every second, whatever the rate. A TAP_BITS-wide binary counter of those strobes drives the taps, and its wrap is the one-second strobe. Changing the rate code restarts the whole chain, so no partial second from the previous rate is carried over.

Top module: `timebase_prescaler`

## Requirements
- R1: While reset is asserted and on the first sample after it, tick_sec, tick_fast and taps are all zero.
- R2: Rate code 0 (low-rate crystal) gives a tick_sec period of exactly XTAL_LO_HZ input cycles.
- R3: Rate codes 1, 2 and 3 give tick_sec periods of exactly 1x, 2x and 4x MHZ_BASE input cycles.
- R4: Rate codes 4 and 5 give tick_sec periods of exactly LINE_A_HZ (50) and LINE_B_HZ (60) input cycles.
- R5: The reserved rate codes 6 and 7 behave like code 0.
- R6: tick_sec is high for exactly one input cycle at a time.
- R7: Exactly 2^TAP_BITS tick_fast pulses occur in each tick_sec period, counting the pulse that coincides with tick_sec. tick_sec is only ever high in a cycle where tick_fast is high.
- R8: taps is a binary count of tick_fast pulses, with taps[0] as the least significant bit. It advances by one, modulo 2^TAP_BITS, in each tick_fast cycle, and it reads all zeros in every tick_sec cycle.
- R9: When rate_sel changes, the accumulator and the tap counter are cleared on the first rising edge that sees the new code. The first tick_sec under the new rate F follows exactly F rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Squared-up input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Input-rate code: 0 low crystal, 1/2/3 one/two/four times MHZ_BASE, 4 line A, 5 line B, 6/7 as 0 |
| tick_sec | output | 1 | One-cycle strobe once per second |
| tick_fast | output | 1 | One-cycle strobe, 2^TAP_BITS per second |
| taps | output | TAP_BITS | Binary count of fast strobes; bit i is a square wave at 2^(TAP_BITS-1-i) Hz |

## Verification
The bench changes rate_sel just after a falling edge. The rising edge that follows clears the chain, and tick_sec then appears on the sample taken after F further rising edges, so the bench expects it on sample F+1. All results are registered at the same edge as tick_sec, so tick_fast, taps and tick_sec are read together on falling-edge samples. From one tick_sec to the next the bench expects exactly F samples, counts the fast strobes and follows taps sample by sample. A restart in mid-second, and a reset in mid-run, are measured against the same schedule.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    // Input-rate codes carried on rate_sel
    typedef enum logic [2:0] {
        RATE_XTAL_LO = 3'd0,
        RATE_MHZ_X1  = 3'd1,
        RATE_MHZ_X2  = 3'd2,
        RATE_MHZ_X4  = 3'd3,
        RATE_LINE_A  = 3'd4,
        RATE_LINE_B  = 3'd5,
        RATE_RSVD_6  = 3'd6,
        RATE_RSVD_7  = 3'd7
    } rate_sel_e;

endpackage

// File: rtl/rate_select.sv
module rate_select
    import tbase_pkg::*;
#(
    parameter int XTAL_LO_HZ = 32768,
    parameter int MHZ_BASE   = 1000000,
    parameter int LINE_A_HZ  = 50,
    parameter int LINE_B_HZ  = 60,
    parameter int ACC_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       rate_sel,
    output logic [ACC_W-1:0] modulus,
    output logic             restart
);

    typedef struct packed {
        logic [2:0] sel;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.sel = rate_sel;
        restart = (rate_sel != s_q.sel);
        case (rate_sel_e'(rate_sel))
            RATE_MHZ_X1: modulus = ACC_W'(MHZ_BASE);
            RATE_MHZ_X2: modulus = ACC_W'(2 * MHZ_BASE);
            RATE_MHZ_X4: modulus = ACC_W'(4 * MHZ_BASE);
            RATE_LINE_A: modulus = ACC_W'(LINE_A_HZ);
            RATE_LINE_B: modulus = ACC_W'(LINE_B_HZ);
            default:     modulus = ACC_W'(XTAL_LO_HZ);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: a code that was stable over the last edge raises no restart
    a_r9_stable_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(rate_sel) && !$past(restart)) |-> !restart);

endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
    parameter int TAP_BITS = 5,
    parameter int ACC_W    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [ACC_W-1:0] modulus,
    output logic             step_now,
    output logic             tick_fast
);

    localparam int             INC_I = 2 ** TAP_BITS;
    localparam logic [ACC_W-1:0] INC = ACC_W'(INC_I);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             fast;
    } state_t;

    state_t           s_d, s_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        s_d      = s_q;
        sum      = s_q.acc + INC;
        step_now = !restart && (sum >= modulus);
        if (restart)       s_d.acc = '0;
        else if (step_now) s_d.acc = sum - modulus;
        else               s_d.acc = sum;
        s_d.fast = step_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_fast = s_q.fast;

    // R7: the running remainder stays below the selected rate
    a_r7_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (s_q.acc < modulus));

endmodule

// File: rtl/tap_counter.sv
module tap_counter #(
    parameter int TAP_BITS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                step,
    output logic [TAP_BITS-1:0] taps,
    output logic                tick_sec
);

    typedef struct packed {
        logic [TAP_BITS-1:0] cnt;
        logic                sec;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.sec = 1'b0;
        if (restart) begin
            s_d.cnt = '0;
        end else if (step) begin
            s_d.cnt = s_q.cnt + 1'b1;
            s_d.sec = &s_q.cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign taps     = s_q.cnt;
    assign tick_sec = s_q.sec;

    // R6: the second strobe never lasts two cycles
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sec |=> !tick_sec);

    // R8: the tap count has just wrapped when the second strobe shows
    a_r8_taps_zero_at_sec: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sec |-> (taps == '0));

endmodule

// File: rtl/timebase_prescaler.sv
module timebase_prescaler #(
    parameter int XTAL_LO_HZ = 32768,
    parameter int MHZ_BASE   = 1000000,
    parameter int LINE_A_HZ  = 50,
    parameter int LINE_B_HZ  = 60,
    parameter int TAP_BITS   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          rate_sel,
    output logic                tick_sec,
    output logic                tick_fast,
    output logic [TAP_BITS-1:0] taps
);

    localparam int MAX_A = (XTAL_LO_HZ > 4 * MHZ_BASE) ? XTAL_LO_HZ : 4 * MHZ_BASE;
    localparam int MAX_B = (LINE_A_HZ > LINE_B_HZ) ? LINE_A_HZ : LINE_B_HZ;
    localparam int MAX_F = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int ACC_W = $clog2(MAX_F + 2 ** TAP_BITS) + 1;

    logic [ACC_W-1:0] modulus;
    logic             restart;
    logic             step_now;

    rate_select #(
        .XTAL_LO_HZ (XTAL_LO_HZ),
        .MHZ_BASE   (MHZ_BASE),
        .LINE_A_HZ  (LINE_A_HZ),
        .LINE_B_HZ  (LINE_B_HZ),
        .ACC_W      (ACC_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .modulus  (modulus),
        .restart  (restart)
    );

    frac_accum #(
        .TAP_BITS (TAP_BITS),
        .ACC_W    (ACC_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .modulus   (modulus),
        .step_now  (step_now),
        .tick_fast (tick_fast)
    );

    tap_counter #(
        .TAP_BITS (TAP_BITS)
    ) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .step     (step_now),
        .taps     (taps),
        .tick_sec (tick_sec)
    );

    // R7: a second strobe always coincides with a fast strobe
    a_r7_sec_on_fast: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sec |-> tick_fast);

    // R9: a rate change leaves the tap counter cleared with no strobe
    a_r9_clear_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (taps == '0 && !tick_sec && !tick_fast));

endmodule

// File: tb/sim_timebase_prescaler.sv
module sim_timebase_prescaler;

    localparam int XLO  = 64;
    localparam int MB   = 100;
    localparam int TB   = 5;
    localparam int NFST = 2 ** TB;
    localparam int NROW = 8;

    // stimulus rate code and expected period in cycles
    localparam int ROW_SEL[NROW] = '{1, 2, 3, 4, 5, 6, 0, 7};
    localparam int ROW_PER[NROW] = '{MB, 2 * MB, 4 * MB, 50, 60, XLO, XLO, XLO};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    rate_sel = 3'd0;
    logic          tick_sec, tick_fast;
    logic [TB-1:0] taps;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    timebase_prescaler #(
        .XTAL_LO_HZ (XLO),
        .MHZ_BASE   (MB),
        .LINE_A_HZ  (50),
        .LINE_B_HZ  (60),
        .TAP_BITS   (TB)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .tick_sec  (tick_sec),
        .tick_fast (tick_fast),
        .taps      (taps)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int sel);
        if (sel == 0) return "R2";
        if (sel <= 3) return "R3";
        if (sel <= 5) return "R4";
        return "R5";
    endfunction

    // set a code, then check latency, period, strobes and taps for one second
    task automatic run_rate(input int sel, input int per);
        int lat, p, fasts, tapbad, width_bad, prev;
        string rq;
        rq = req_of(sel);
        @(negedge clk);
        rate_sel = 3'(sel);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!tick_sec && lat < 2000);
        chk("R9", "first tick after rate change", lat, per + 1);
        chk("R8", "taps at first tick", int'(taps), 0);
        prev = 0; fasts = 0; tapbad = 0;
        @(negedge clk);
        p = 1;
        width_bad = tick_sec ? 1 : 0;
        forever begin
            if (tick_fast) begin
                fasts++;
                if (int'(taps) != ((prev + 1) % NFST)) tapbad++;
                prev = int'(taps);
            end
            if (tick_sec && p > 1) break;
            if (p > 2000) break;
            @(negedge clk);
            p++;
        end
        chk(rq, "tick_sec period", p, per);
        chk("R6", "tick_sec width over one cycle", width_bad, 0);
        chk("R7", "fast strobes per second", fasts, NFST);
        chk("R8", "tap count steps", tapbad, 0);
        chk("R8", "taps at tick", int'(taps), 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "tick_sec in reset", int'(tick_sec), 0);
        chk("R1", "tick_fast in reset", int'(tick_fast), 0);
        chk("R1", "taps in reset", int'(taps), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outputs after release", int'({tick_sec, tick_fast, taps}), 0);

        for (int i = 0; i < NROW; i++) run_rate(ROW_SEL[i], ROW_PER[i]);

        // R9: change code in mid-second, no partial second carried
        @(negedge clk);
        rate_sel = 3'd3;
        repeat (150) @(negedge clk);
        run_rate(4, 50);

        // R1: reset in mid-run clears outputs
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "outputs in mid-run reset", int'({tick_sec, tick_fast, taps}), 0);
        rst_n = 1'b1;
        run_rate(5, 60);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait (cyc >= 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule